// File: doc/BRIEF.md
# Integer-to-Float Conversion Unit

This block is a pipelined execution unit that turns an integer operand into a half, single or double precision floating-point value. Each cycle it accepts one 64-bit instruction word and one 64-bit source operand, qualified by a valid strobe. The instruction word decides how the source is read: as a byte or halfword picked by a selector, as a 32-bit word, or as the full 64 bits. It also decides whether the source is signed, whether the absolute value is taken, whether the result is negated, which rounding direction applies, and which destination register receives the result.

The result leaves the unit exactly two cycles after it was accepted. The unit also gives the destination register index and one write enable per 32-bit register half. A double result writes a pair of registers. Encodings the unit does not support raise an illegal flag. When that flag is set, the write enables stay low and the data is zero. The instruction issue logic feeds the unit every cycle and never sees back-pressure. The register-file write port takes the result.

Top module: `i2f_unit`

## Requirements
- R1: An instruction accepted with `in_valid` high at a rising edge produces `out_valid` high after the second following rising edge. `out_valid` is low two edges after a cycle without `in_valid`, and it is low after reset.
- R2: Instruction fields: destination index bits 7:0, float format bits 9:8 (1 half, 2 single, 3 double), integer format bits 11:10 (0 byte, 1 halfword, 2 word, 3 doubleword), signed flag bit 13, rounding bits 40:39, selector bits 42:41, negate bit 45, condition-code enable bit 47, abs bit 49. A float format of 0 or a set bit 47 raises `out_illegal`.
- R3: The selector must be 0 or 2 for the halfword format, and 0 for the word and doubleword formats. Any other value raises `out_illegal`.
- R4: For the byte format, the byte at bit offset selector×8 of the low 32 source bits is used. For the halfword format, the halfword at selector×8 is used. The word format uses bits 31:0 and the doubleword format uses all 64 bits. The value is sign-extended when the signed flag is 1 and zero-extended when it is 0.
- R5: With abs set, a negative byte or halfword becomes its magnitude. Word and doubleword sources take abs only when signed. In every format, the most negative value of the source width is left unchanged.
- R6: With negate set, the result sign is inverted whenever abs is set or the source is unsigned. Otherwise it is inverted only when the extended value is not the most negative value of its width. This makes the negate of an unsigned zero equal to minus zero.
- R7: A half result occupies `out_data[15:0]` with bits 63:16 zero. A single result occupies `out_data[31:0]` with bits 63:32 zero. In both cases only `out_we_lo` is raised.
- R8: A double result fills `out_data[63:0]`. The low word goes to the destination register and the high word to the next one, so both `out_we_lo` and `out_we_hi` are raised. An odd destination index with the double format raises `out_illegal`.
- R9: Results that cannot be held exactly are rounded by the rounding field: 0 to nearest with ties to even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero.
- R10: A half result larger than the largest finite half becomes infinity under rounding 0, under rounding 1 when negative, and under rounding 2 when positive. In the other cases it becomes the largest finite half (0x7BFF with the sign bit set as needed).
- R11: While `out_illegal` is high, `out_we_lo` and `out_we_hi` are low and `out_data` is zero. None of the three outputs is high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operand present this cycle |
| in_insn | input | 64 | Instruction word |
| in_src | input | 64 | Integer source operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Converted value, zero-padded by format |
| out_dst | output | 8 | Destination register index |
| out_we_lo | output | 1 | Write `out_data[31:0]` to register `out_dst` |
| out_we_hi | output | 1 | Write `out_data[63:32]` to register `out_dst`+1 |
| out_illegal | output | 1 | Unsupported or malformed encoding |

## Verification
The checker watches every cycle for four things: the two-cycle valid latency, the suppression of writes and data under the illegal flag, the pairing of the high write enable with an even index, and the zero upper bits of half and single results. It also checks that a set condition-code bit or a bad halfword selector always ends as an illegal result. The numerical parts can be shown only by the bench scenarios, which compare every cycle against an arithmetic model. These parts are the sub-field extraction, the abs and negate rules at the minimum integer, ties-to-even, the directed rounding modes and half-precision overflow saturation.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

    localparam int INSN_W = 64;
    localparam int SRC_W  = 64;
    localparam int LO_W   = 32;
    localparam int REG_W  = 8;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int FMT_N  = 3;

    // Field positions inside the instruction word
    localparam int POS_DST = 0;
    localparam int POS_FF  = 8;
    localparam int POS_IF  = 10;
    localparam int POS_SGN = 13;
    localparam int POS_RND = 39;
    localparam int POS_SEL = 41;
    localparam int POS_NEG = 45;
    localparam int POS_CC  = 47;
    localparam int POS_ABS = 49;

    typedef enum logic [1:0] {
        FF_BAD    = 2'd0,
        FF_HALF   = 2'd1,
        FF_SINGLE = 2'd2,
        FF_DOUBLE = 2'd3
    } ffmt_e;

    typedef enum logic [1:0] {
        IF_B8  = 2'd0,
        IF_H16 = 2'd1,
        IF_W32 = 2'd2,
        IF_D64 = 2'd3
    } ifmt_e;

    typedef enum logic [1:0] {
        RD_NEAR = 2'd0,
        RD_DOWN = 2'd1,
        RD_UP   = 2'd2,
        RD_ZERO = 2'd3
    } rnd_e;

    typedef struct packed {
        logic [REG_W-1:0] dst;
        ffmt_e            ff;
        ifmt_e            itf;
        logic             sgn;
        rnd_e             rnd;
        logic [1:0]       sel;
        logic             neg;
        logic             absf;
    } op_t;

    // Mantissa / exponent widths per format slot (0 half, 1 single, 2 double)
    function automatic int mant_w(input int slot);
        return (slot == 0) ? 10 : (slot == 1) ? 23 : 52;
    endfunction

    function automatic int exp_w(input int slot);
        return (slot == 0) ? 5 : (slot == 1) ? 8 : 11;
    endfunction

    // Extend the low w bits of v to SRC_W, by sign or by zero
    function automatic logic [SRC_W-1:0] ext_of(input logic [SRC_W-1:0] v,
                                                 input int w, input logic s);
        logic [SRC_W-1:0] keep;
        keep = (SRC_W'(1) << w) - SRC_W'(1);
        if (w >= SRC_W) keep = '1;
        if (s && v[w-1]) return (v & keep) | ~keep;
        return v & keep;
    endfunction

    // Most negative value of width w, sign-extended to SRC_W
    function automatic logic [SRC_W-1:0] min_of(input int w);
        return ~((SRC_W'(1) << (w - 1)) - SRC_W'(1));
    endfunction

endpackage

// File: rtl/i2f_decode.sv
module i2f_decode
    import i2f_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output op_t               op,
    output logic              bad
);

    logic sel_bad;
    logic unused_insn;

    assign unused_insn = ^insn;

    always_comb begin
        op.dst  = insn[POS_DST +: REG_W];
        op.ff   = ffmt_e'(insn[POS_FF +: 2]);
        op.itf  = ifmt_e'(insn[POS_IF +: 2]);
        op.sgn  = insn[POS_SGN];
        op.rnd  = rnd_e'(insn[POS_RND +: 2]);
        op.sel  = insn[POS_SEL +: 2];
        op.neg  = insn[POS_NEG];
        op.absf = insn[POS_ABS];

        unique case (op.itf)
            IF_B8:   sel_bad = 1'b0;
            IF_H16:  sel_bad = op.sel[0];
            default: sel_bad = (op.sel != 2'd0);
        endcase

        bad = (op.ff == FF_BAD)
            | insn[POS_CC]
            | sel_bad
            | ((op.ff == FF_DOUBLE) & op.dst[0]);
    end

endmodule

// File: rtl/i2f_prep.sv
module i2f_prep
    import i2f_pkg::*;
(
    input  ifmt_e             itf,
    input  logic              sgn,
    input  logic [1:0]        sel,
    input  logic              neg,
    input  logic              absf,
    input  logic [SRC_W-1:0]  src,
    output logic              sign,
    output logic [SRC_W-1:0]  mag
);

    logic [LO_W-1:0]  shifted;
    logic [SRC_W-1:0] ext;
    logic [SRC_W-1:0] minv;
    logic [SRC_W-1:0] after_abs;
    logic             abs_ok;
    logic             is_min;
    logic             neg_pre;
    logic             neg_post;
    logic             flip;

    assign shifted = src[LO_W-1:0] >> {sel, 3'b000};

    always_comb begin
        unique case (itf)
            IF_B8: begin
                ext    = ext_of(SRC_W'(shifted), BYTE_W, sgn);
                minv   = min_of(BYTE_W);
                abs_ok = absf;
            end
            IF_H16: begin
                ext    = ext_of(SRC_W'(shifted), HALF_W, sgn);
                minv   = min_of(HALF_W);
                abs_ok = absf;
            end
            IF_W32: begin
                ext    = ext_of(SRC_W'(shifted), LO_W, sgn);
                minv   = min_of(LO_W);
                abs_ok = absf & sgn;
            end
            IF_D64: begin
                ext    = src;
                minv   = min_of(SRC_W);
                abs_ok = absf & sgn;
            end
        endcase

        is_min    = sgn & (ext == minv);
        neg_pre   = sgn & ext[SRC_W-1];
        after_abs = (abs_ok & neg_pre & ~is_min) ? (~ext + SRC_W'(1)) : ext;
        neg_post  = sgn & after_abs[SRC_W-1];
        mag       = neg_post ? (~after_abs + SRC_W'(1)) : after_abs;
        flip      = neg & (absf | ~sgn | ~is_min);
        sign      = neg_post ^ flip;
    end

endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
#(
    parameter int MANT_W = 23,
    parameter int EXP_W  = 8
) (
    input  logic [SRC_W-1:0]          mag,
    input  logic                      sign,
    input  rnd_e                      rnd,
    output logic [EXP_W+MANT_W:0]     res
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EU_W = 12;

    logic [5:0]        lead;
    logic              nonzero;
    logic [SRC_W-1:0]  norm;
    logic [MANT_W-1:0] frac;
    logic              guard;
    logic              sticky;
    logic              bump;
    logic [MANT_W:0]   sum;
    logic [EU_W-1:0]   e_unb;
    logic [EU_W-1:0]   e_bias;
    logic              ovf;
    logic              to_inf;
    logic              unused_r;

    always_comb begin
        lead = 6'd0;
        for (int i = 0; i < SRC_W; i++) begin
            if (mag[i]) lead = 6'(i);
        end
    end

    assign nonzero = |mag;
    assign norm    = mag << (6'd63 - lead);
    assign frac    = norm[SRC_W-2 -: MANT_W];
    assign guard   = norm[SRC_W-2-MANT_W];
    assign sticky  = |norm[SRC_W-3-MANT_W:0];

    always_comb begin
        unique case (rnd)
            RD_NEAR: bump = guard & (sticky | frac[0]);
            RD_DOWN: bump = (guard | sticky) & sign;
            RD_UP:   bump = (guard | sticky) & ~sign;
            RD_ZERO: bump = 1'b0;
        endcase
    end

    assign sum    = {1'b0, frac} + (MANT_W+1)'(bump);
    assign e_unb  = EU_W'(lead) + EU_W'(sum[MANT_W]);
    assign e_bias = e_unb + EU_W'(BIAS);
    assign ovf    = e_unb > EU_W'(BIAS);
    assign to_inf = (rnd == RD_NEAR) | ((rnd == RD_DOWN) & sign) | ((rnd == RD_UP) & ~sign);

    always_comb begin
        if (!nonzero)
            res = {sign, {(EXP_W+MANT_W){1'b0}}};
        else if (ovf && to_inf)
            res = {sign, {EXP_W{1'b1}}, {MANT_W{1'b0}}};
        else if (ovf)
            res = {sign, {(EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};
        else
            res = {sign, e_bias[EXP_W-1:0], sum[MANT_W-1:0]};
    end

    assign unused_r = ^{norm[SRC_W-1], e_bias};

endmodule

// File: rtl/i2f_unit.sv
module i2f_unit
    import i2f_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       in_insn,
    input  logic [63:0]       in_src,
    output logic              out_valid,
    output logic [63:0]       out_data,
    output logic [7:0]        out_dst,
    output logic              out_we_lo,
    output logic              out_we_hi,
    output logic              out_illegal
);

    // Stage 0: decode and operand preparation (combinational)
    op_t              op0;
    logic             bad0;
    logic             sign0;
    logic [SRC_W-1:0] mag0;

    i2f_decode u_dec (
        .insn (in_insn),
        .op   (op0),
        .bad  (bad0)
    );

    i2f_prep u_prep (
        .itf  (op0.itf),
        .sgn  (op0.sgn),
        .sel  (op0.sel),
        .neg  (op0.neg),
        .absf (op0.absf),
        .src  (in_src),
        .sign (sign0),
        .mag  (mag0)
    );

    // Stage 1 registers
    logic             v1;
    logic             bad1;
    logic             sign1;
    logic [SRC_W-1:0] mag1;
    ffmt_e            ff1;
    rnd_e             rnd1;
    logic [REG_W-1:0] dst1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            bad1  <= 1'b0;
            sign1 <= 1'b0;
            mag1  <= '0;
            ff1   <= FF_BAD;
            rnd1  <= RD_NEAR;
            dst1  <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                bad1  <= bad0;
                sign1 <= sign0;
                mag1  <= mag0;
                ff1   <= op0.ff;
                rnd1  <= op0.rnd;
                dst1  <= op0.dst;
            end
        end
    end

    // Stage 1: one rounding path per float format
    logic [SRC_W-1:0] fp_res [FMT_N];

    for (genvar g = 0; g < FMT_N; g++) begin : g_fmt
        localparam int MW = mant_w(g);
        localparam int EW = exp_w(g);
        logic [EW+MW:0] r;

        i2f_round #(.MANT_W(MW), .EXP_W(EW)) u_rnd (
            .mag  (mag1),
            .sign (sign1),
            .rnd  (rnd1),
            .res  (r)
        );

        assign fp_res[g] = SRC_W'(r);
    end

    logic [SRC_W-1:0] fp_sel;

    always_comb begin
        unique case (ff1)
            FF_HALF:   fp_sel = fp_res[0];
            FF_SINGLE: fp_sel = fp_res[1];
            FF_DOUBLE: fp_sel = fp_res[2];
            FF_BAD:    fp_sel = '0;
        endcase
    end

    // Stage 2 registers
    logic             v2;
    logic             ill2;
    logic             dbl2;
    logic [SRC_W-1:0] data2;
    logic [REG_W-1:0] dst2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2    <= 1'b0;
            ill2  <= 1'b0;
            dbl2  <= 1'b0;
            data2 <= '0;
            dst2  <= '0;
        end else begin
            v2    <= v1;
            ill2  <= v1 & bad1;
            dbl2  <= (ff1 == FF_DOUBLE);
            data2 <= (v1 && !bad1) ? fp_sel : '0;
            dst2  <= dst1;
        end
    end

    always_comb begin
        out_valid   = v2;
        out_illegal = ill2;
        out_we_lo   = v2 & ~ill2;
        out_we_hi   = v2 & ~ill2 & dbl2;
        out_data    = data2;
        out_dst     = dst2;
    end

endmodule

// File: rtl/i2f_unit_chk.sv
module i2f_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        ins_cc,
    input logic [1:0]  ins_ff,
    input logic [1:0]  ins_if,
    input logic        ins_sel_lsb,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic        dst_lsb,
    input logic        out_we_lo,
    input logic        out_we_hi,
    input logic        out_illegal
);

    // R1
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R1
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R2
    cc_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_cc) |=> ##1 out_illegal);

    // R3
    half_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_if == 2'd1 && ins_sel_lsb) |=> ##1 out_illegal);

    // R7
    half_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_ff == 2'd1) |=> ##1 (out_data[63:16] == '0));

    // R7
    single_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_ff == 2'd2) |=> ##1 (out_data[63:32] == '0));

    // R8
    pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we_hi |-> (out_we_lo && !dst_lsb));

    // R11
    no_we_on_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_we_lo && !out_we_hi && out_data == '0));

    // R11
    needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we_lo || out_we_hi || out_illegal) |-> out_valid);

endmodule

bind i2f_unit i2f_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .ins_cc      (in_insn[47]),
    .ins_ff      (in_insn[9:8]),
    .ins_if      (in_insn[11:10]),
    .ins_sel_lsb (in_insn[41]),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .dst_lsb     (out_dst[0]),
    .out_we_lo   (out_we_lo),
    .out_we_hi   (out_we_hi),
    .out_illegal (out_illegal)
);

// File: tb/i2f_unit_test.sv
`timescale 1ns/1ps
module i2f_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_insn = '0;
    logic [63:0] in_src = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [7:0]  out_dst;
    logic        out_we_lo;
    logic        out_we_hi;
    logic        out_illegal;

    i2f_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn), .in_src(in_src),
        .out_valid(out_valid), .out_data(out_data), .out_dst(out_dst),
        .out_we_lo(out_we_lo), .out_we_hi(out_we_hi), .out_illegal(out_illegal)
    );

    always #2 clk = ~clk;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_tag = "R1";

    typedef struct {
        bit          v;
        logic [63:0] d;
        logic [7:0]  dst;
        bit          wl;
        bit          wh;
        bit          il;
        string       tag;
    } exp_t;

    exp_t p0, p1;

    function automatic logic [63:0] mk(int dst, int ff, int itf, bit sg, int rm,
                                       int sel, bit ng, bit cc, bit ab);
        logic [63:0] x = '0;
        x[7:0]   = 8'(dst);
        x[9:8]   = 2'(ff);
        x[11:10] = 2'(itf);
        x[13]    = sg;
        x[40:39] = 2'(rm);
        x[42:41] = 2'(sel);
        x[45]    = ng;
        x[47]    = cc;
        x[49]    = ab;
        return x;
    endfunction

    // Arithmetic model of integer-to-float with a remainder comparison
    function automatic logic [63:0] ref_fp(logic [63:0] mag, bit s, int mw, int ew, int rm);
        int          p, e, bias, sh;
        logic [63:0] m, rem, halfv, sgnbit;
        bit          up;
        bias   = (1 << (ew - 1)) - 1;
        sgnbit = 64'(s) << (mw + ew);
        if (mag == 0) return sgnbit;
        p = 63;
        while (!mag[p]) p--;
        if (p <= mw) begin
            m = mag << (mw - p); rem = 0; halfv = 1;
        end else begin
            sh = p - mw;
            m = mag >> sh;
            rem = mag & ((64'd1 << sh) - 1);
            halfv = 64'd1 << (sh - 1);
        end
        case (rm)
            0: up = (rem > halfv) || (rem == halfv && m[0]);
            1: up = (rem != 0) && s;
            2: up = (rem != 0) && !s;
            default: up = 0;
        endcase
        m = m + 64'(up);
        e = p;
        if (m == (64'd1 << (mw + 1))) begin m = m >> 1; e++; end
        if (e > bias) begin
            if (rm == 0 || (rm == 1 && s) || (rm == 2 && !s))
                return sgnbit | (((64'd1 << ew) - 1) << mw);
            return sgnbit | (((64'd1 << ew) - 2) << mw) | ((64'd1 << mw) - 1);
        end
        return sgnbit | (64'(e + bias) << mw) | (m & ((64'd1 << mw) - 1));
    endfunction

    function automatic exp_t ref_op(logic [63:0] insn, logic [63:0] src, string tag);
        exp_t        r;
        int          ff, itf, rm, sel, w;
        bit          sg, ng, cc, ab, ill, isneg, flip, s;
        logic [63:0] val, minv, mag;
        logic [31:0] lo;
        ff = int'(insn[9:8]); itf = int'(insn[11:10]); sg = insn[13];
        rm = int'(insn[40:39]); sel = int'(insn[42:41]);
        ng = insn[45]; cc = insn[47]; ab = insn[49];
        lo = src[31:0] >> (sel * 8);
        case (itf)
            0: begin w = 8;  val = sg ? {{56{lo[7]}},  lo[7:0]}  : {56'd0, lo[7:0]}; end
            1: begin w = 16; val = sg ? {{48{lo[15]}}, lo[15:0]} : {48'd0, lo[15:0]}; end
            2: begin w = 32; val = sg ? {{32{src[31]}}, src[31:0]} : {32'd0, src[31:0]}; end
            default: begin w = 64; val = src; end
        endcase
        minv = -(64'd1 << (w - 1));
        if (ab && (itf < 2 || sg) && sg && val[63] && val != minv) val = -val;
        isneg = sg && val[63];
        mag   = isneg ? -val : val;
        flip  = ng && (ab || !sg || val != minv);
        s     = isneg ^ flip;
        ill   = (ff == 0) || cc || (itf == 1 && (sel % 2) == 1) || (itf >= 2 && sel != 0)
                || (ff == 3 && insn[0]);
        r.v   = 1; r.dst = insn[7:0]; r.il = ill; r.wl = !ill; r.wh = !ill && ff == 3;
        r.tag = tag;
        case (ff)
            1: r.d = ref_fp(mag, s, 10, 5, rm);
            2: r.d = ref_fp(mag, s, 23, 8, rm);
            3: r.d = ref_fp(mag, s, 52, 11, rm);
            default: r.d = 0;
        endcase
        if (ill) r.d = 0;
        return r;
    endfunction

    // Reference pipeline, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p0.v = 0; p1.v = 0;
        end else begin
            p1 = p0;
            if (in_valid) p0 = ref_op(in_insn, in_src, cur_tag);
            else p0.v = 0;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_run++;
            if (out_valid !== p1.v) begin
                n_fail++;
                $display("FAIL R1 out_valid=%b expected=%b", out_valid, p1.v);
            end else if (p1.v) begin
                n_run++;
                if (out_data !== p1.d || out_dst !== p1.dst || out_we_lo !== p1.wl ||
                    out_we_hi !== p1.wh || out_illegal !== p1.il) begin
                    n_fail++;
                    $display("FAIL %s data=%h dst=%h wl=%b wh=%b il=%b expected data=%h dst=%h wl=%b wh=%b il=%b",
                             p1.tag, out_data, out_dst, out_we_lo, out_we_hi, out_illegal,
                             p1.d, p1.dst, p1.wl, p1.wh, p1.il);
                end
            end else if (out_we_lo || out_we_hi || out_illegal) begin
                n_fail++;
                $display("FAIL R11 idle we_lo=%b we_hi=%b il=%b expected 0 0 0",
                         out_we_lo, out_we_hi, out_illegal);
            end
        end
    end

    task automatic send(logic [63:0] insn, logic [63:0] src, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_insn = insn; in_src = src; cur_tag = tag;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_insn = '0; in_src = '0;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R1 watchdog expired, expected run to finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_run++;
        if (out_valid !== 1'b0 || out_we_lo !== 1'b0 || out_we_hi !== 1'b0 ||
            out_illegal !== 1'b0 || out_data !== 64'd0) begin
            n_fail++;
            $display("FAIL R1 reset valid=%b data=%h expected 0 0", out_valid, out_data);
        end
        rst_n = 1'b1;
        idle(2);

        // R4 sub-field extraction and extension
        send(mk(2, 2, 0, 1, 0, 2, 0, 0, 0), 64'h0000_0000_0080_0000, "R4");
        send(mk(2, 2, 0, 0, 0, 2, 0, 0, 0), 64'h0000_0000_0080_0000, "R4");
        send(mk(3, 2, 1, 1, 0, 2, 0, 0, 0), 64'h0000_0000_FFFE_0000, "R4");
        send(mk(3, 2, 1, 0, 0, 0, 0, 0, 0), 64'hFFFF_FFFF_1234_FFFE, "R4");
        send(mk(4, 1, 0, 0, 0, 3, 0, 0, 0), 64'h0000_0000_AB00_0000, "R4");
        send(mk(4, 2, 2, 1, 0, 0, 0, 0, 0), 64'hAAAA_AAAA_FFFF_FF85, "R4");
        idle(1);
        // R5 abs rules
        send(mk(5, 2, 0, 1, 0, 0, 0, 0, 1), 64'h80, "R5");
        send(mk(5, 2, 0, 1, 0, 0, 0, 0, 1), 64'hFB, "R5");
        send(mk(5, 2, 1, 0, 0, 0, 0, 0, 1), 64'h8000, "R5");
        send(mk(5, 2, 2, 0, 0, 0, 0, 0, 1), 64'hFFFF_FFFF, "R5");
        send(mk(5, 2, 2, 1, 0, 0, 0, 0, 1), 64'h8000_0000, "R5");
        send(mk(6, 3, 3, 1, 0, 0, 0, 0, 1), 64'hFFFF_FFFF_FFFF_FFF9, "R5");
        // R6 negate rules
        send(mk(6, 2, 1, 1, 0, 0, 1, 0, 0), 64'h8000, "R6");
        send(mk(6, 2, 0, 1, 0, 0, 1, 0, 0), 64'h03, "R6");
        send(mk(6, 1, 2, 0, 0, 0, 1, 0, 0), 64'h0, "R6");
        send(mk(6, 2, 0, 1, 0, 0, 1, 0, 1), 64'h80, "R6");
        send(mk(6, 3, 3, 1, 0, 0, 1, 0, 0), 64'h8000_0000_0000_0000, "R6");
        send(mk(6, 2, 2, 1, 0, 0, 1, 0, 0), 64'h0, "R6");
        idle(2);
        // R7 packing
        send(mk(7, 1, 2, 0, 0, 0, 0, 0, 0), 64'h1, "R7");
        send(mk(9, 2, 2, 0, 0, 0, 0, 0, 0), 64'hFF, "R7");
        // R8 double pair
        send(mk(4, 3, 3, 1, 0, 0, 0, 0, 0), 64'h1234_5678_9ABC_DEF1, "R8");
        send(mk(5, 3, 2, 1, 0, 0, 0, 0, 0), 64'h7, "R8");
        send(mk(254, 3, 2, 0, 0, 0, 0, 0, 0), 64'hFFFF_FFFF, "R8");
        // R9 rounding
        for (int m = 0; m < 4; m++) begin
            send(mk(1, 2, 2, 0, m, 0, 0, 0, 0), 64'h0100_0001, "R9");
            send(mk(1, 2, 2, 0, m, 0, 0, 0, 0), 64'h0100_0003, "R9");
            send(mk(1, 2, 2, 1, m, 0, 0, 0, 0), 64'hFEFF_FFFF, "R9");
            send(mk(2, 3, 3, 0, m, 0, 0, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, "R9");
            send(mk(2, 1, 1, 0, m, 0, 0, 0, 0), 64'h0801, "R9");
        end
        // R10 half overflow
        for (int m = 0; m < 4; m++) begin
            send(mk(3, 1, 2, 0, m, 0, 0, 0, 0), 64'd65520, "R10");
            send(mk(3, 1, 2, 0, m, 0, 1, 0, 0), 64'd65520, "R10");
            send(mk(3, 1, 2, 0, m, 0, 0, 0, 0), 64'd65504, "R10");
            send(mk(3, 1, 3, 1, m, 0, 0, 0, 0), 64'h8000_0000_0000_0000, "R10");
        end
        idle(1);
        // R2 illegal encodings
        send(mk(1, 0, 2, 0, 0, 0, 0, 0, 0), 64'h5, "R2");
        send(mk(1, 2, 2, 0, 0, 0, 0, 1, 0), 64'h5, "R2");
        // R3 selector legality
        send(mk(1, 2, 1, 0, 0, 1, 0, 0, 0), 64'h1234_5678, "R3");
        send(mk(1, 2, 1, 0, 0, 3, 0, 0, 0), 64'h1234_5678, "R3");
        send(mk(1, 2, 2, 0, 0, 1, 0, 0, 0), 64'h1234_5678, "R3");
        send(mk(1, 3, 3, 0, 0, 2, 0, 0, 0), 64'h1234_5678, "R3");
        send(mk(1, 2, 0, 0, 0, 3, 0, 0, 0), 64'h1234_5678, "R3");
        // R11 illegal with double to odd register, data and writes suppressed
        send(mk(9, 3, 3, 1, 0, 0, 1, 1, 1), 64'hFFFF_0000_FFFF_0000, "R11");
        idle(3);

        // Mixed stream with gaps, checked against the model every cycle (R9)
        for (int i = 0; i < 600; i++) begin
            logic [63:0] ins, src;
            ins = {$urandom, $urandom};
            if ($urandom % 8 != 0) ins[47] = 1'b0;
            if ($urandom % 4 != 0) ins[42:41] = (ins[11:10] == 2'd1) ? {ins[42], 1'b0} :
                                                (ins[11:10] == 2'd0) ? ins[42:41] : 2'd0;
            if ($urandom % 6 != 0 && ins[9:8] == 2'd0) ins[9:8] = 2'd2;
            src = {$urandom, $urandom};
            if ($urandom % 3 == 0) src = src >> ($urandom % 64);
            send(ins, src, "R9");
            if ($urandom % 5 == 0) idle(1 + ($urandom % 3));
        end
        idle(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule